// File: doc/BRIEF.md
# Host Bridge Window Register Block

This block holds the programmable state that a PCI host bridge uses to map bus-master addresses onto system memory. It keeps one 64-bit control word and, for each of four address windows, a 64-bit window base, a 64-bit window mask and a 64-bit translated base. All registers are reached through a simple single-beat read/write request port. The register number is derived from the byte address. The window words and the control word leave the block on wide output buses that feed the address translator.

Three extra indices behave specially:
- An error-status word reads as zero and silently takes writes.
- An error-mask word reads as zero.
- A translation-flush word takes writes, discards the value and reads as zero.

Every other index, and every access narrower than 64 bits, completes with an error response instead of stalling the bus. Such an access returns zero data and leaves the stored state untouched.

Each request gets exactly one response, one clock later. Writes land at the same clock edge that accepts them, so a read issued in the very next cycle already sees the new value.

Top module: `hbrRegs`

## Requirements
- R1: After reset every window base, window mask and translated-base register is zero, and the control register holds 64'h0000_0021_0010_0000 (bits 20 and 32 set, value 2 in the field starting at bit 36). This holds both on the export buses and on readback.
- R2: The register index is (reqAddr - BASE_ADDR) >> 6, so the low six address bits are ignored. Index 0 is control, index 1 is error status, index 2 is error mask and index 3 is translation flush. Indices 4+w, 8+w and 12+w are window w's base, mask and translated base, for w = 0..3. Window w occupies bits [64*w+63 : 64*w] of each export bus.
- R3: rspValid is high in exactly the cycle after a cycle with reqValid high, and low otherwise.
- R4: A legal 64-bit write (reqSize == 3) to a storage register changes it at the accepting edge, with no error. A read returns the register's value with rspError low. A read in the cycle right after the write returns the new value.
- R5: An access with reqSize other than 3 (0 = 8-bit, 1 = 16-bit, 2 = 32-bit) returns rspError high and zero data, and changes no register.
- R6: The error-status index reads as zero without error. A write to it completes without error and changes no register.
- R7: The error-mask index reads as zero without error. A write to it is unsupported and returns an error.
- R8: The translation-flush index reads as zero without error. A write to it completes without error and its value is discarded.
- R9: Any index not listed in R2, including addresses below BASE_ADDR, returns rspError high and zero data, and changes no register.
- R10: Writing one window register leaves every other register unchanged.
- R11: Write responses always carry zero data, and the state exports do not change in a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqSize | input | 2 | Access size code: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| reqWdata | input | 64 | Write data |
| rspValid | output | 1 | Response present, one cycle after the request |
| rspError | output | 1 | Request was unsupported or had an illegal size |
| rspRdata | output | 64 | Read data, zero for writes and errors |
| ctrlReg | output | 64 | Current control word |
| winBase | output | 256 | Window base registers, window w in bits [64w+63:64w] |
| winMask | output | 256 | Window mask registers, same packing |
| winXlate | output | 256 | Translated-base registers, same packing |

## Verification
Two functions share a cycle:
- A register write lands at an edge while the response of the previous request is still being presented.
- The very next request may read the register that was just written.

The bench provokes both by issuing requests back to back with no idle cycles, including a write to a translated-base register followed at once by a read of the same index. A behavioural model updates its state at issue time and compares the response and every export bus on each clock. A stale read or an early or late response therefore shows up as a mismatch.

// File: rtl/hbrPkg.sv
package hbrPkg;
  localparam int unsigned HBR_DATA_W      = 64;
  localparam int unsigned HBR_NUM_WIN     = 4;
  localparam int unsigned HBR_WIN_IDX_W   = (HBR_NUM_WIN > 1) ? $clog2(HBR_NUM_WIN) : 1;
  localparam int unsigned HBR_STRIDE_LOG2 = 6;
  localparam logic [1:0]  HBR_SIZE_DW     = 2'd3;

  localparam logic [HBR_DATA_W-1:0] HBR_CTRL_RESET =
    (64'h1 << 20) | (64'h1 << 32) | (64'h2 << 36);

  localparam int unsigned IDX_CTRL     = 0;
  localparam int unsigned IDX_ERR_STAT = 1;
  localparam int unsigned IDX_ERR_MASK = 2;
  localparam int unsigned IDX_FLUSH    = 3;
  localparam int unsigned IDX_BASE0    = 4;
  localparam int unsigned IDX_MASK0    = IDX_BASE0 + HBR_NUM_WIN;
  localparam int unsigned IDX_XLATE0   = IDX_MASK0 + HBR_NUM_WIN;
  localparam int unsigned IDX_END      = IDX_XLATE0 + HBR_NUM_WIN;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_CTRL,
    SEL_BASE,
    SEL_MASK,
    SEL_XLATE
  } regSel_e;

  typedef struct packed {
    logic                     wrEn;
    logic                     rdEn;
    regSel_e                  sel;
    logic [HBR_WIN_IDX_W-1:0] win;
  } strobe_t;
endpackage

// File: rtl/hbrDecode.sv
module hbrDecode
  import hbrPkg::*;
#(
  parameter int unsigned       ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  output strobe_t           strb,
  output logic              rspValid,
  output logic              rspError
);
  localparam int unsigned IDX_W = ADDR_W - HBR_STRIDE_LOG2;

  logic [IDX_W-1:0] regIdx;
  logic [31:0]      idxWide;
  logic             sizeOk;
  logic             rdOk;
  logic             wrOk;
  logic             legal;
  regSel_e          selNext;
  logic [31:0]      winWide;

  assign regIdx  = IDX_W'((reqAddr - BASE_ADDR) >> HBR_STRIDE_LOG2);
  assign idxWide = 32'(regIdx);
  assign sizeOk  = (reqSize == HBR_SIZE_DW);

  always_comb begin
    selNext = SEL_ZERO;
    rdOk    = 1'b0;
    wrOk    = 1'b0;
    winWide = '0;
    if (idxWide == IDX_CTRL) begin
      selNext = SEL_CTRL;
      rdOk    = 1'b1;
      wrOk    = 1'b1;
    end else if (idxWide == IDX_ERR_STAT) begin
      rdOk = 1'b1;
      wrOk = 1'b1;
    end else if (idxWide == IDX_ERR_MASK) begin
      rdOk = 1'b1;
    end else if (idxWide == IDX_FLUSH) begin
      rdOk = 1'b1;
      wrOk = 1'b1;
    end else if (idxWide >= IDX_BASE0 && idxWide < IDX_MASK0) begin
      selNext = SEL_BASE;
      winWide = idxWide - IDX_BASE0;
      rdOk    = 1'b1;
      wrOk    = 1'b1;
    end else if (idxWide >= IDX_MASK0 && idxWide < IDX_XLATE0) begin
      selNext = SEL_MASK;
      winWide = idxWide - IDX_MASK0;
      rdOk    = 1'b1;
      wrOk    = 1'b1;
    end else if (idxWide >= IDX_XLATE0 && idxWide < IDX_END) begin
      selNext = SEL_XLATE;
      winWide = idxWide - IDX_XLATE0;
      rdOk    = 1'b1;
      wrOk    = 1'b1;
    end
  end

  assign legal     = reqValid && sizeOk && (reqWrite ? wrOk : rdOk);
  assign strb.wrEn = legal && reqWrite;
  assign strb.rdEn = legal && !reqWrite;
  assign strb.sel  = selNext;
  assign strb.win  = HBR_WIN_IDX_W'(winWide);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspError <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspError <= reqValid && !legal;
    end
  end
endmodule

// File: rtl/hbrRegFile.sv
module hbrRegFile
  import hbrPkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  strobe_t                           strb,
  input  logic [HBR_DATA_W-1:0]             wdata,
  output logic [HBR_DATA_W-1:0]             rdata,
  output logic [HBR_DATA_W-1:0]             ctrlOut,
  output logic [HBR_NUM_WIN*HBR_DATA_W-1:0] baseOut,
  output logic [HBR_NUM_WIN*HBR_DATA_W-1:0] maskOut,
  output logic [HBR_NUM_WIN*HBR_DATA_W-1:0] xlateOut
);
  logic [HBR_DATA_W-1:0] ctrlQ;
  logic [HBR_DATA_W-1:0] baseQ  [HBR_NUM_WIN];
  logic [HBR_DATA_W-1:0] maskQ  [HBR_NUM_WIN];
  logic [HBR_DATA_W-1:0] xlateQ [HBR_NUM_WIN];
  logic [HBR_DATA_W-1:0] readMux;

  always_ff @(posedge clk) begin
    if (!rstN)                                   ctrlQ <= HBR_CTRL_RESET;
    else if (strb.wrEn && strb.sel == SEL_CTRL)  ctrlQ <= wdata;
  end

  for (genvar w = 0; w < HBR_NUM_WIN; w++) begin : gWin
    logic hit;
    assign hit = strb.wrEn && (strb.win == HBR_WIN_IDX_W'(w));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[w]  <= '0;
        maskQ[w]  <= '0;
        xlateQ[w] <= '0;
      end else if (hit) begin
        if (strb.sel == SEL_BASE)  baseQ[w]  <= wdata;
        if (strb.sel == SEL_MASK)  maskQ[w]  <= wdata;
        if (strb.sel == SEL_XLATE) xlateQ[w] <= wdata;
      end
    end

    assign baseOut [w*HBR_DATA_W +: HBR_DATA_W] = baseQ[w];
    assign maskOut [w*HBR_DATA_W +: HBR_DATA_W] = maskQ[w];
    assign xlateOut[w*HBR_DATA_W +: HBR_DATA_W] = xlateQ[w];
  end

  always_comb begin
    case (strb.sel)
      SEL_CTRL:  readMux = ctrlQ;
      SEL_BASE:  readMux = baseQ[strb.win];
      SEL_MASK:  readMux = maskQ[strb.win];
      SEL_XLATE: readMux = xlateQ[strb.win];
      default:   readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdata <= '0;
    else if (strb.rdEn) rdata <= readMux;
    else                rdata <= '0;
  end

  assign ctrlOut = ctrlQ;
endmodule

// File: rtl/hbrRegs.sv
module hbrRegs
  import hbrPkg::*;
#(
  parameter int unsigned       ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h4000
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              reqValid,
  input  logic                              reqWrite,
  input  logic [ADDR_W-1:0]                 reqAddr,
  input  logic [1:0]                        reqSize,
  input  logic [HBR_DATA_W-1:0]             reqWdata,
  output logic                              rspValid,
  output logic                              rspError,
  output logic [HBR_DATA_W-1:0]             rspRdata,
  output logic [HBR_DATA_W-1:0]             ctrlReg,
  output logic [HBR_NUM_WIN*HBR_DATA_W-1:0] winBase,
  output logic [HBR_NUM_WIN*HBR_DATA_W-1:0] winMask,
  output logic [HBR_NUM_WIN*HBR_DATA_W-1:0] winXlate
);
  strobe_t strb;

  hbrDecode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) uDecode (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .strb     (strb),
    .rspValid (rspValid),
    .rspError (rspError)
  );

  hbrRegFile uRegFile (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wdata    (reqWdata),
    .rdata    (rspRdata),
    .ctrlOut  (ctrlReg),
    .baseOut  (winBase),
    .maskOut  (winMask),
    .xlateOut (winXlate)
  );
endmodule

// File: rtl/hbrRegsChk.sv
module hbrRegsChk
  import hbrPkg::*;
#(
  parameter int unsigned       ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h4000
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              reqValid,
  input logic                              reqWrite,
  input logic [ADDR_W-1:0]                 reqAddr,
  input logic [1:0]                        reqSize,
  input logic [HBR_DATA_W-1:0]             reqWdata,
  input logic                              rspValid,
  input logic                              rspError,
  input logic [HBR_DATA_W-1:0]             rspRdata,
  input logic [HBR_DATA_W-1:0]             ctrlReg,
  input logic [HBR_NUM_WIN*HBR_DATA_W-1:0] winBase,
  input logic [HBR_NUM_WIN*HBR_DATA_W-1:0] winMask,
  input logic [HBR_NUM_WIN*HBR_DATA_W-1:0] winXlate
);
  localparam int unsigned IDX_W = ADDR_W - HBR_STRIDE_LOG2;

  logic [IDX_W-1:0] chkIdx;
  assign chkIdx = IDX_W'((reqAddr - BASE_ADDR) >> HBR_STRIDE_LOG2);

  assert_rsp_follows_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_no_spurious_rsp_R3: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  assert_bad_size_error_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize != HBR_SIZE_DW) |=> (rspError && rspRdata == '0));

  assert_bad_size_no_change_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize != HBR_SIZE_DW) |=>
      ($stable(ctrlReg) && $stable(winBase) && $stable(winMask) && $stable(winXlate)));

  assert_ctrl_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqSize == HBR_SIZE_DW && chkIdx == '0) |=>
      (ctrlReg == $past(reqWdata) && !rspError));

  assert_error_data_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspError) |-> rspRdata == '0);

  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=>
      ($stable(ctrlReg) && $stable(winBase) && $stable(winMask) && $stable(winXlate)));

  assert_write_rsp_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> rspRdata == '0);
endmodule

bind hbrRegs hbrRegsChk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqWrite (reqWrite),
  .reqAddr  (reqAddr),
  .reqSize  (reqSize),
  .reqWdata (reqWdata),
  .rspValid (rspValid),
  .rspError (rspError),
  .rspRdata (rspRdata),
  .ctrlReg  (ctrlReg),
  .winBase  (winBase),
  .winMask  (winMask),
  .winXlate (winXlate)
);

// File: tb/tb_hbrRegs.sv
module tb_hbrRegs;
  localparam int          AW   = 20;
  localparam logic [19:0] BASE = 20'h04000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqWrite = 1'b0;
  logic [19:0]  reqAddr = '0;
  logic [1:0]   reqSize = 2'd3;
  logic [63:0]  reqWdata = '0;
  logic         rspValid, rspError;
  logic [63:0]  rspRdata, ctrlReg;
  logic [255:0] winBase, winMask, winXlate;

  int checks = 0;
  int errors = 0;

  logic [63:0] mCtrl;
  logic [63:0] mBase [4];
  logic [63:0] mMask [4];
  logic [63:0] mXlate[4];

  always #10ns clk = ~clk;

  hbrRegs #(.ADDR_W(AW), .BASE_ADDR(BASE)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspError(rspError), .rspRdata(rspRdata),
    .ctrlReg(ctrlReg), .winBase(winBase), .winMask(winMask), .winXlate(winXlate)
  );

  function automatic logic [19:0] ra(input int idx);
    return BASE + 20'(idx * 64);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkState(input string req);
    for (int w = 0; w < 4; w++) begin
      check(winBase[w*64 +: 64] == mBase[w], req, "winBase", winBase[w*64 +: 64], mBase[w]);
      check(winMask[w*64 +: 64] == mMask[w], req, "winMask", winMask[w*64 +: 64], mMask[w]);
      check(winXlate[w*64 +: 64] == mXlate[w], req, "winXlate", winXlate[w*64 +: 64], mXlate[w]);
    end
    check(ctrlReg == mCtrl, req, "ctrlReg", ctrlReg, mCtrl);
  endtask

  // Issue one cycle (request or idle); check its response one cycle later.
  task automatic step(input bit v, input bit wr, input logic [19:0] addr,
                      input logic [1:0] size, input logic [63:0] data, input string req);
    logic [19:0] off;
    int idx;
    bit err;
    logic [63:0] expData;
    off = addr - BASE;
    idx = int'(off[19:6]);
    err = 1'b0;
    expData = '0;
    reqValid = v; reqWrite = wr; reqAddr = addr; reqSize = size; reqWdata = data;
    if (v) begin
      if (size != 2'd3) err = 1'b1;
      else if (idx == 0) begin
        if (wr) mCtrl = data; else expData = mCtrl;
      end else if (idx == 1 || idx == 3) begin
        expData = '0;
      end else if (idx == 2) begin
        err = wr;
      end else if (idx >= 4 && idx < 8) begin
        if (wr) mBase[idx-4] = data; else expData = mBase[idx-4];
      end else if (idx >= 8 && idx < 12) begin
        if (wr) mMask[idx-8] = data; else expData = mMask[idx-8];
      end else if (idx >= 12 && idx < 16) begin
        if (wr) mXlate[idx-12] = data; else expData = mXlate[idx-12];
      end else err = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid == v, req, "rspValid", 64'(rspValid), 64'(v));
    if (v) begin
      check(rspError == err, req, "rspError", 64'(rspError), 64'(err));
      check(rspRdata == expData, req, "rspRdata", rspRdata, expData);
    end
    checkState(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mCtrl = 64'h0000_0021_0010_0000;
    for (int w = 0; w < 4; w++) begin
      mBase[w] = '0; mMask[w] = '0; mXlate[w] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, R3: no response while idle
    step(0, 0, '0, 2'd3, '0, "R1/R3 reset idle");
    step(1, 0, ra(0), 2'd3, '0, "R1 ctrl reset readback");
    step(1, 0, ra(6), 2'd3, '0, "R1 base2 reset readback");
    step(1, 0, ra(13), 2'd3, '0, "R1 xlate1 reset readback");
    // R4 / R10: write each window register with distinct data
    for (int w = 0; w < 4; w++) begin
      step(1, 1, ra(4+w),  2'd3, 64'hB000_0000_0000_0000 | 64'(w*17+1), "R4/R10 base write");
      step(1, 1, ra(8+w),  2'd3, 64'h0000_00FF_F000_0000 ^ 64'(w << 20), "R4/R10 mask write");
      step(1, 1, ra(12+w), 2'd3, 64'h5A5A_0000_1234_0000 + 64'(w), "R4/R10 xlate write");
    end
    // R4: back-to-back write then read of same register; R2: low bits ignored
    step(1, 1, ra(13), 2'd3, 64'hDEAD_BEEF_CAFE_F00D, "R4 xlate1 write");
    step(1, 0, ra(13) + 20'h2C, 2'd3, '0, "R2/R4 xlate1 read next cycle, offset bits");
    step(1, 0, ra(9) + 20'h3F, 2'd3, '0, "R2 mask1 read offset 3F");
    step(1, 1, ra(0), 2'd3, 64'hFFFF_0000_AAAA_5555, "R4 ctrl write");
    step(1, 0, ra(0), 2'd3, '0, "R4 ctrl read");
    step(1, 0, ra(7), 2'd3, '0, "R4 base3 read");
    // R5: illegal sizes
    step(1, 1, ra(5), 2'd2, 64'h1111_2222_3333_4444, "R5 32-bit write");
    step(1, 0, ra(5), 2'd0, '0, "R5 8-bit read");
    step(1, 1, ra(0), 2'd1, 64'h0, "R5 16-bit ctrl write");
    step(1, 0, ra(5), 2'd3, '0, "R5 base1 unchanged");
    // R6: error status
    step(1, 1, ra(1), 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R6 err status write");
    step(1, 0, ra(1), 2'd3, '0, "R6 err status read zero");
    // R7: error mask
    step(1, 0, ra(2), 2'd3, '0, "R7 err mask read zero");
    step(1, 1, ra(2), 2'd3, 64'h1234, "R7 err mask write error");
    // R8: translation flush
    step(1, 1, ra(3), 2'd3, 64'h8765_4321_0000_FFFF, "R8 flush write");
    step(1, 0, ra(3), 2'd3, '0, "R8 flush read zero");
    // R9: unsupported indices
    step(1, 1, ra(16), 2'd3, 64'h77, "R9 index 16 write");
    step(1, 0, ra(100), 2'd3, '0, "R9 index 100 read");
    step(1, 1, BASE - 20'd64, 2'd3, 64'h99, "R9 below base write");
    step(1, 0, BASE - 20'd1, 2'd3, '0, "R9 below base read");
    // R11: idle cycles keep state
    step(0, 0, ra(4), 2'd3, 64'hFFFF, "R11 idle");
    step(0, 1, ra(4), 2'd3, 64'hFFFF, "R11 idle with write fields");
    step(1, 0, ra(4), 2'd3, '0, "R11 base0 after idle");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule